// File: doc/BRIEF.md
# USB PHY Power Sequencer

This block is a hardware state machine that brings one of four USB PHY ports up or down: the device port, the host port, or one of two inter-chip ports. It owns the control-register images of the host PHY, the OTG block, the two inter-chip PHYs and the EHCI/OHCI glue, and drives them out as plain ports. It also owns the host/device mode-switch bit and one isolation bit each for the device and host ports. A single command carries the direction (power-on or power-off), the port, and the reference clock rate in kHz.

Each power-on writes a fixed, ordered chain of reset, hold and release steps. The microsecond holds are counted in system clock cycles by one shared down-counter, with the length derived from the `CLK_HZ` parameter. A power-on with an unsupported reference rate is refused, raises an error, and leaves every output untouched. Isolation is lifted as the very last step of a power-on, and it is raised before anything else at power-off.

Top module: `usbphy_pwr_seq`

## Requirements
- R1: After reset, busy, done and err are 0 and the mode bit is 1 (host). Both isolation bits are 1. The host image holds only bit 6 (power-down), the OTG image only bit 1 (power-down), and both inter-chip images only bit 6 (power-down). The EHCI and OHCI images are 0.
- R2: A power-on maps the rate in kHz to a 3-bit frequency code: 24000→5, 20000→4, 50000→7, 9600→0, 12000→2, 19200→3, 10000→1. The code lands in OTG bits [6:4], and on the host/inter-chip path also in host bits [18:16].
- R3: A power-on with any other rate gives done and err in the cycle after acceptance. Busy is never raised, and no image, mode or isolation bit changes.
- R4: A device power-on clears the mode bit to 0 (device). It leaves OTG with the frequency code, reference select bits [10:9] = 2, and bits 0 (suspend), 1 (power-down), 3 (sleep), 2 (OTG-disable) and 12/13/14 (resets) all at 0.
- R5: On device power-on, OTG bits 12, 13, 14 and 2 are high together for exactly 100 µs worth of cycles (100·CLK_HZ/10^6).
- R6: A host or inter-chip power-on leaves host bit 9 set. It clears bits 0, 31, 6, 4, 5, 1 and 2, and host bits 1 (link reset) and 2 (UTMI reset) are high for exactly 10 µs of cycles.
- R7: On the host/inter-chip path, the OTG reset bits 12/13/14 are high for exactly 10 µs of cycles. OTG-disable (bit 2) stays set afterwards, and the reference select is 2.
- R8: On the host/inter-chip path, both inter-chip images end at divider 0x24 in bits [22:16] and reference select 2 in bits [24:23]. Their reset (bit 0) is high for exactly 10 µs of cycles. The EHCI image changes exactly 80 µs of cycles after that reset falls.
- R9: A host/inter-chip power-on sets EHCI bits 26, 27, 28 and 29 and OHCI bit 3, leaving other bits as they were.
- R10: Power-on lowers the port's isolation bit (device or host) in the same cycle as done. An inter-chip power-on changes neither isolation bit.
- R11: Power-off raises the port's isolation bit before any image bit changes. Device off then sets OTG bits 0, 1 and 3. Host off sets host bits 6, 4, 5, 0 and 31. Inter-chip off writes both inter-chip images to divider 0x24, reference select 2, and bits 6, 5 and 4.
- R12: Busy is high from the cycle after acceptance until done, done is a one-cycle pulse, and a command presented while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_on | input | 1 | 1 = power-on, 0 = power-off |
| cmd_port | input | 2 | 0 device, 1 host, 2 inter-chip 0, 3 inter-chip 1 |
| cmd_rate_khz | input | RATE_W | Reference clock rate in kHz |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rate refused, valid with done |
| mode_host | output | 1 | Mode switch: 1 host, 0 device |
| iso_dev | output | 1 | Device port isolation, 1 = isolated |
| iso_host | output | 1 | Host port isolation, 1 = isolated |
| host_ctrl | output | 32 | Host PHY control image |
| otg_ctrl | output | 32 | OTG control image |
| hsic0_ctrl | output | 32 | Inter-chip PHY 0 control image |
| hsic1_ctrl | output | 32 | Inter-chip PHY 1 control image |
| ehci_ctrl | output | 32 | EHCI control image |
| ohci_ctrl | output | 32 | OHCI control image |

## Verification
The bench builds the sequencer with CLK_HZ set to 2 MHz, so one microsecond is two cycles. That makes the 100 µs device hold 200 cycles and the 10 µs holds 20 cycles, so an off-by-one in the counter load shows up as a measured hold of 199 or 201. The 80 µs settle becomes 160 cycles, and a full host power-on fits in about 230 cycles, so dozens of random commands run alongside the directed cases. Because the three hold lengths differ, a wrong hold choice on either path is visible.

// File: rtl/usbphy_seq_pkg.sv
package usbphy_seq_pkg;

    localparam int IMG_W = 32;

    typedef enum logic [1:0] {
        PORT_DEV   = 2'd0,
        PORT_HOST  = 2'd1,
        PORT_HSIC0 = 2'd2,
        PORT_HSIC1 = 2'd3
    } port_e;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_D_MODE,
        ST_H_RST,
        ST_H_WAIT,
        ST_H_REL,
        ST_O_RST,
        ST_O_WAIT,
        ST_O_REL,
        ST_S_RST,
        ST_S_WAIT,
        ST_S_REL,
        ST_S_SETTLE,
        ST_BURST,
        ST_UNISO,
        ST_ISO,
        ST_OFF
    } state_e;

    // host PHY control image
    localparam int HC_RSTALL   = 31;
    localparam int HC_REFSEL   = 19;
    localparam int HC_FSEL     = 16;
    localparam int HC_COMMON_N = 9;
    localparam int HC_SIDDQ    = 6;
    localparam int HC_SLEEP    = 5;
    localparam int HC_SUSP     = 4;
    localparam int HC_UTMI_RST = 2;
    localparam int HC_LINK_RST = 1;
    localparam int HC_PHY_RST  = 0;

    // OTG control image
    localparam int OG_PLINK_RST = 14;
    localparam int OG_LINK_RST  = 13;
    localparam int OG_PHY_RST   = 12;
    localparam int OG_REFSEL    = 9;
    localparam int OG_FSEL      = 4;
    localparam int OG_SLEEP     = 3;
    localparam int OG_DISABLE   = 2;
    localparam int OG_SIDDQ     = 1;
    localparam int OG_SUSP      = 0;

    // inter-chip PHY control image
    localparam int HS_REFSEL  = 23;
    localparam int HS_DIV     = 16;
    localparam int HS_SIDDQ   = 6;
    localparam int HS_SLEEP   = 5;
    localparam int HS_SUSP    = 4;
    localparam int HS_PHY_RST = 0;

    // burst enables and OHCI bit
    localparam int EH_ALIGN  = 29;
    localparam int EH_INCR4  = 28;
    localparam int EH_INCR8  = 27;
    localparam int EH_INCR16 = 26;
    localparam int OH_LEGACY = 3;

    localparam logic [1:0] REFSEL_CORE = 2'd2;
    localparam logic [6:0] HS_DIV_VAL  = 7'h24;

    typedef struct packed {
        state_e           st;
        port_e            port;
        logic [2:0]       fsel;
        logic [IMG_W-1:0] hc;
        logic [IMG_W-1:0] otg;
        logic [IMG_W-1:0] hs;
        logic [IMG_W-1:0] ehci;
        logic [IMG_W-1:0] ohci;
        logic             mode_host;
        logic             iso_dev;
        logic             iso_host;
        logic             done;
        logic             err;
    } seq_regs_t;

endpackage

// File: rtl/usbphy_rate_enc.sv
module usbphy_rate_enc #(
    parameter int RATE_W = 16
) (
    input  logic [RATE_W-1:0] rate_khz,
    output logic [2:0]        code,
    output logic              ok
);
    always_comb begin
        ok   = 1'b1;
        code = 3'd0;
        case (rate_khz)
            RATE_W'(9600):  code = 3'd0;
            RATE_W'(10000): code = 3'd1;
            RATE_W'(12000): code = 3'd2;
            RATE_W'(19200): code = 3'd3;
            RATE_W'(20000): code = 3'd4;
            RATE_W'(24000): code = 3'd5;
            RATE_W'(50000): code = 3'd7;
            default: begin
                ok   = 1'b0;
                code = 3'd0;
            end
        endcase
    end
endmodule

// File: rtl/usbphy_hold_timer.sv
module usbphy_hold_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/usbphy_pwr_seq.sv
module usbphy_pwr_seq
    import usbphy_seq_pkg::*;
#(
    parameter int CLK_HZ        = 100_000_000,
    parameter int LONG_HOLD_US  = 100,
    parameter int SHORT_HOLD_US = 10,
    parameter int SETTLE_US     = 80,
    parameter int RATE_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_on,
    input  logic [1:0]        cmd_port,
    input  logic [RATE_W-1:0] cmd_rate_khz,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              mode_host,
    output logic              iso_dev,
    output logic              iso_host,
    output logic [31:0]       host_ctrl,
    output logic [31:0]       otg_ctrl,
    output logic [31:0]       hsic0_ctrl,
    output logic [31:0]       hsic1_ctrl,
    output logic [31:0]       ehci_ctrl,
    output logic [31:0]       ohci_ctrl
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int LONG_CYC   = LONG_HOLD_US * CYC_PER_US;
    localparam int SHORT_CYC  = SHORT_HOLD_US * CYC_PER_US;
    localparam int SETTLE_CYC = SETTLE_US * CYC_PER_US;
    localparam int MAX_A      = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int MAX_CYC    = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);
    // a step cycle plus the final wait cycle frame the count: load two less
    localparam logic [CNT_W-1:0] LD_LONG   = CNT_W'(LONG_CYC - 2);
    localparam logic [CNT_W-1:0] LD_SHORT  = CNT_W'(SHORT_CYC - 2);
    localparam logic [CNT_W-1:0] LD_SETTLE = CNT_W'(SETTLE_CYC - 2);

    seq_regs_t        r_d, r_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic [2:0]       rate_code;
    logic             rate_ok;

    usbphy_rate_enc #(.RATE_W(RATE_W)) u_rate (
        .rate_khz (cmd_rate_khz),
        .code     (rate_code),
        .ok       (rate_ok)
    );

    usbphy_hold_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (r_q.st)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (cmd_on && !rate_ok) begin
                        r_d.done = 1'b1;
                        r_d.err  = 1'b1;
                    end else begin
                        r_d.port = port_e'(cmd_port);
                        r_d.fsel = rate_code;
                        if (!cmd_on)
                            r_d.st = ST_ISO;
                        else if (port_e'(cmd_port) == PORT_DEV)
                            r_d.st = ST_D_MODE;
                        else
                            r_d.st = ST_H_RST;
                    end
                end
            end
            ST_D_MODE: begin
                r_d.mode_host = 1'b0;
                r_d.st        = ST_O_RST;
            end
            ST_H_RST: begin
                r_d.hc[HC_FSEL +: 3]  = r_q.fsel;
                r_d.hc[HC_PHY_RST]    = 1'b0;
                r_d.hc[HC_RSTALL]     = 1'b0;
                r_d.hc[HC_SIDDQ]      = 1'b0;
                r_d.hc[HC_SUSP]       = 1'b0;
                r_d.hc[HC_SLEEP]      = 1'b0;
                r_d.hc[HC_LINK_RST]   = 1'b1;
                r_d.hc[HC_UTMI_RST]   = 1'b1;
                r_d.hc[HC_COMMON_N]   = 1'b1;
                tmr_load              = 1'b1;
                tmr_val               = LD_SHORT;
                r_d.st                = ST_H_WAIT;
            end
            ST_H_WAIT: if (tmr_expired) r_d.st = ST_H_REL;
            ST_H_REL: begin
                r_d.hc[HC_LINK_RST] = 1'b0;
                r_d.hc[HC_UTMI_RST] = 1'b0;
                r_d.st              = ST_O_RST;
            end
            ST_O_RST: begin
                r_d.otg[OG_FSEL +: 3]   = r_q.fsel;
                r_d.otg[OG_SUSP]        = 1'b0;
                r_d.otg[OG_SLEEP]       = 1'b0;
                r_d.otg[OG_SIDDQ]       = 1'b0;
                r_d.otg[OG_PHY_RST]     = 1'b1;
                r_d.otg[OG_PLINK_RST]   = 1'b1;
                r_d.otg[OG_LINK_RST]    = 1'b1;
                r_d.otg[OG_DISABLE]     = 1'b1;
                r_d.otg[OG_REFSEL +: 2] = REFSEL_CORE;
                tmr_load                = 1'b1;
                tmr_val                 = (r_q.port == PORT_DEV) ? LD_LONG : LD_SHORT;
                r_d.st                  = ST_O_WAIT;
            end
            ST_O_WAIT: if (tmr_expired) r_d.st = ST_O_REL;
            ST_O_REL: begin
                r_d.otg[OG_PHY_RST]   = 1'b0;
                r_d.otg[OG_PLINK_RST] = 1'b0;
                r_d.otg[OG_LINK_RST]  = 1'b0;
                if (r_q.port == PORT_DEV) begin
                    r_d.otg[OG_DISABLE] = 1'b0;
                    r_d.st              = ST_UNISO;
                end else begin
                    r_d.st = ST_S_RST;
                end
            end
            ST_S_RST: begin
                r_d.hs                = '0;
                r_d.hs[HS_DIV +: 7]   = HS_DIV_VAL;
                r_d.hs[HS_REFSEL +: 2] = REFSEL_CORE;
                r_d.hs[HS_PHY_RST]    = 1'b1;
                tmr_load              = 1'b1;
                tmr_val               = LD_SHORT;
                r_d.st                = ST_S_WAIT;
            end
            ST_S_WAIT: if (tmr_expired) r_d.st = ST_S_REL;
            ST_S_REL: begin
                r_d.hs[HS_PHY_RST] = 1'b0;
                tmr_load           = 1'b1;
                tmr_val            = LD_SETTLE;
                r_d.st             = ST_S_SETTLE;
            end
            ST_S_SETTLE: if (tmr_expired) r_d.st = ST_BURST;
            ST_BURST: begin
                r_d.ehci[EH_ALIGN]  = 1'b1;
                r_d.ehci[EH_INCR4]  = 1'b1;
                r_d.ehci[EH_INCR8]  = 1'b1;
                r_d.ehci[EH_INCR16] = 1'b1;
                r_d.ohci[OH_LEGACY] = 1'b1;
                r_d.st              = ST_UNISO;
            end
            ST_UNISO: begin
                if (r_q.port == PORT_DEV)  r_d.iso_dev  = 1'b0;
                if (r_q.port == PORT_HOST) r_d.iso_host = 1'b0;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            ST_ISO: begin
                if (r_q.port == PORT_DEV)  r_d.iso_dev  = 1'b1;
                if (r_q.port == PORT_HOST) r_d.iso_host = 1'b1;
                r_d.st = ST_OFF;
            end
            ST_OFF: begin
                case (r_q.port)
                    PORT_DEV: begin
                        r_d.otg[OG_SUSP]  = 1'b1;
                        r_d.otg[OG_SIDDQ] = 1'b1;
                        r_d.otg[OG_SLEEP] = 1'b1;
                    end
                    PORT_HOST: begin
                        r_d.hc[HC_SIDDQ]   = 1'b1;
                        r_d.hc[HC_SUSP]    = 1'b1;
                        r_d.hc[HC_SLEEP]   = 1'b1;
                        r_d.hc[HC_PHY_RST] = 1'b1;
                        r_d.hc[HC_RSTALL]  = 1'b1;
                    end
                    default: begin
                        r_d.hs                 = '0;
                        r_d.hs[HS_DIV +: 7]    = HS_DIV_VAL;
                        r_d.hs[HS_REFSEL +: 2] = REFSEL_CORE;
                        r_d.hs[HS_SIDDQ]       = 1'b1;
                        r_d.hs[HS_SLEEP]       = 1'b1;
                        r_d.hs[HS_SUSP]        = 1'b1;
                    end
                endcase
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q               <= '0;
            r_q.st            <= ST_IDLE;
            r_q.port          <= PORT_DEV;
            r_q.hc[HC_SIDDQ]  <= 1'b1;
            r_q.otg[OG_SIDDQ] <= 1'b1;
            r_q.hs[HS_SIDDQ]  <= 1'b1;
            r_q.mode_host     <= 1'b1;
            r_q.iso_dev       <= 1'b1;
            r_q.iso_host      <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st != ST_IDLE);
    assign done       = r_q.done;
    assign err        = r_q.err;
    assign mode_host  = r_q.mode_host;
    assign iso_dev    = r_q.iso_dev;
    assign iso_host   = r_q.iso_host;
    assign host_ctrl  = r_q.hc;
    assign otg_ctrl   = r_q.otg;
    assign hsic0_ctrl = r_q.hs;
    assign hsic1_ctrl = r_q.hs;
    assign ehci_ctrl  = r_q.ehci;
    assign ohci_ctrl  = r_q.ohci;
endmodule

// File: rtl/usbphy_pwr_seq_chk.sv
module usbphy_pwr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic err,
    input logic mode_host,
    input logic iso_dev,
    input logic iso_host,
    input logic otg_siddq,
    input logic host_siddq,
    input logic burst_bit,
    input logic hsic_rst
);
    // R12
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R12
    busy_ends_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R3
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R10
    dev_iso_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_dev) |-> done);

    // R10
    host_iso_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_host) |-> done);

    // R11
    otg_pd_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(otg_siddq) |-> iso_dev);

    // R11
    host_pd_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_siddq) |-> iso_host);

    // R4
    mode_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_host) |-> busy);

    // R9
    burst_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_bit) |-> (busy && !hsic_rst));
endmodule

bind usbphy_pwr_seq usbphy_pwr_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .mode_host  (mode_host),
    .iso_dev    (iso_dev),
    .iso_host   (iso_host),
    .otg_siddq  (otg_ctrl[1]),
    .host_siddq (host_ctrl[6]),
    .burst_bit  (ehci_ctrl[28]),
    .hsic_rst   (hsic0_ctrl[0])
);

// File: tb/usbphy_pwr_seq_tb.sv
module usbphy_pwr_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TB_CLK_HZ  = 2_000_000;
    localparam int CPU        = TB_CLK_HZ / 1_000_000;
    localparam int LONG_N     = 100 * CPU;
    localparam int SHORT_N    = 10 * CPU;
    localparam int SETTLE_N   = 80 * CPU;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_on = 1'b0;
    logic [1:0]  cmd_port = 2'd0;
    logic [15:0] cmd_rate_khz = 16'd0;
    logic        busy, done, err, mode_host, iso_dev, iso_host;
    logic [31:0] host_ctrl, otg_ctrl, hsic0_ctrl, hsic1_ctrl, ehci_ctrl, ohci_ctrl;

    int tests = 0;
    int fails = 0;

    // expected state
    logic [31:0] m_hc, m_otg, m_hs, m_ehci, m_ohci;
    logic        m_mode, m_iso_dev, m_iso_host;

    // monitors
    int otg_run, otg_last, hc_run, hc_last, hs_run, hs_last, gap, gap_last;
    bit gap_on;
    int ord10, ord11;
    logic p_iso_dev, p_iso_host, p_otg_sd, p_hc_sd, p_hs_rst;
    logic [31:0] p_ehci;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbphy_pwr_seq #(.CLK_HZ(TB_CLK_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_on(cmd_on),
        .cmd_port(cmd_port), .cmd_rate_khz(cmd_rate_khz), .busy(busy),
        .done(done), .err(err), .mode_host(mode_host), .iso_dev(iso_dev),
        .iso_host(iso_host), .host_ctrl(host_ctrl), .otg_ctrl(otg_ctrl),
        .hsic0_ctrl(hsic0_ctrl), .hsic1_ctrl(hsic1_ctrl),
        .ehci_ctrl(ehci_ctrl), .ohci_ctrl(ohci_ctrl)
    );

    function automatic int rate_code(input int khz);
        case (khz)
            9600:  return 0;
            10000: return 1;
            12000: return 2;
            19200: return 3;
            20000: return 4;
            24000: return 5;
            50000: return 7;
            default: return -1;
        endcase
    endfunction

    function automatic int pick_rate(input int idx);
        case (idx)
            0: return 9600;
            1: return 10000;
            2: return 12000;
            3: return 19200;
            4: return 20000;
            5: return 24000;
            default: return 50000;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_hc = 32'h40; m_otg = 32'h2; m_hs = 32'h40;
        m_ehci = 0; m_ohci = 0;
        m_mode = 1'b1; m_iso_dev = 1'b1; m_iso_host = 1'b1;
    endtask

    task automatic model_apply(input logic on, input logic [1:0] port, input int khz);
        int code;
        code = rate_code(khz);
        if (on) begin
            if (code < 0) return;
            // OTG part common to both paths
            m_otg[6:4] = code[2:0];
            m_otg[0] = 0; m_otg[1] = 0; m_otg[3] = 0;
            m_otg[10:9] = 2'd2;
            m_otg[14:12] = 3'b000;
            if (port == 2'd0) begin
                m_mode = 1'b0;
                m_otg[2] = 1'b0;
                m_iso_dev = 1'b0;
            end else begin
                m_otg[2] = 1'b1;
                m_hc[18:16] = code[2:0];
                m_hc[0] = 0; m_hc[31] = 0; m_hc[6] = 0; m_hc[4] = 0; m_hc[5] = 0;
                m_hc[1] = 0; m_hc[2] = 0; m_hc[9] = 1;
                m_hs = (32'h24 << 16) | (32'h2 << 23);
                m_ehci = m_ehci | (32'hF << 26);
                m_ohci = m_ohci | 32'h8;
                if (port == 2'd1) m_iso_host = 1'b0;
            end
        end else begin
            case (port)
                2'd0: begin m_iso_dev = 1'b1; m_otg = m_otg | 32'hB; end
                2'd1: begin m_iso_host = 1'b1; m_hc = m_hc | 32'h8000_0071; end
                default: m_hs = (32'h24 << 16) | (32'h2 << 23) | 32'h70;
            endcase
        end
    endtask

    task automatic compare_all(input string req);
        chk({req, " host_ctrl"}, host_ctrl, m_hc);
        chk({req, " otg_ctrl"}, otg_ctrl, m_otg);
        chk({req, " hsic0_ctrl"}, hsic0_ctrl, m_hs);
        chk({req, " hsic1_ctrl"}, hsic1_ctrl, m_hs);
        chk({req, " ehci_ctrl"}, ehci_ctrl, m_ehci);
        chk({req, " ohci_ctrl"}, ohci_ctrl, m_ohci);
        chk({req, " mode_host"}, {31'd0, mode_host}, {31'd0, m_mode});
        chk({req, " iso_dev"}, {31'd0, iso_dev}, {31'd0, m_iso_dev});
        chk({req, " iso_host"}, {31'd0, iso_host}, {31'd0, m_iso_host});
    endtask

    // drives one command and returns at the negedge where done is seen
    task automatic run_cmd(input logic on, input logic [1:0] port, input int khz,
                           output int cycles, output logic err_seen, output logic busy_seen);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_on = on; cmd_port = port; cmd_rate_khz = khz[15:0];
        @(negedge clk);
        cmd_valid = 1'b0;
        cycles = 1;
        busy_seen = busy;
        while (!done && cycles < 5000) begin
            @(negedge clk);
            cycles++;
            busy_seen = busy_seen | busy;
        end
        err_seen = err;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            otg_run = 0; hc_run = 0; hs_run = 0; gap_on = 0; gap = 0;
            p_iso_dev = iso_dev; p_iso_host = iso_host;
            p_otg_sd = otg_ctrl[1]; p_hc_sd = host_ctrl[6];
            p_hs_rst = hsic0_ctrl[0]; p_ehci = ehci_ctrl;
        end else begin
            if (otg_ctrl[12]) otg_run++;
            else if (otg_run != 0) begin otg_last = otg_run; otg_run = 0; end
            if (host_ctrl[1]) hc_run++;
            else if (hc_run != 0) begin hc_last = hc_run; hc_run = 0; end
            if (hsic0_ctrl[0]) hs_run++;
            else if (hs_run != 0) begin hs_last = hs_run; hs_run = 0; end
            if (gap_on) begin
                gap++;
                if (ehci_ctrl != p_ehci) begin gap_last = gap; gap_on = 0; end
            end
            if (p_hs_rst && !hsic0_ctrl[0]) begin gap_on = 1; gap = 0; end
            if (p_iso_dev && !iso_dev && !done) ord10++;
            if (p_iso_host && !iso_host && !done) ord10++;
            if (!p_otg_sd && otg_ctrl[1] && !iso_dev) ord11++;
            if (!p_hc_sd && host_ctrl[6] && !iso_host) ord11++;
            p_iso_dev = iso_dev; p_iso_host = iso_host;
            p_otg_sd = otg_ctrl[1]; p_hc_sd = host_ctrl[6];
            p_hs_rst = hsic0_ctrl[0]; p_ehci = ehci_ctrl;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R12 watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int cyc;
        logic e_seen, b_seen;
        void'($urandom(32'd20240611));
        otg_last = 0; hc_last = 0; hs_last = 0; gap_last = 0; ord10 = 0; ord11 = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 done", {31'd0, done}, 0);
        chk("R1 err", {31'd0, err}, 0);
        compare_all("R1");

        // R3 refused rate
        run_cmd(1'b1, 2'd1, 13000, cyc, e_seen, b_seen);
        chk("R3 done latency", cyc, 1);
        chk("R3 err", {31'd0, e_seen}, 1);
        chk("R3 busy never", {31'd0, b_seen}, 0);
        compare_all("R3");

        // host power-on first after reset: R6 R7 R8 R9 R10
        run_cmd(1'b1, 2'd1, 12000, cyc, e_seen, b_seen);
        model_apply(1'b1, 2'd1, 12000);
        chk("R12 busy seen", {31'd0, b_seen}, 1);
        chk("R3 no err on valid", {31'd0, e_seen}, 0);
        chk("R6 link reset hold", hc_last, SHORT_N);
        chk("R7 otg reset hold", otg_last, SHORT_N);
        chk("R7 otg disable kept", {31'd0, otg_ctrl[2]}, 1);
        chk("R8 hsic reset hold", hs_last, SHORT_N);
        chk("R8 settle gap", gap_last, SETTLE_N);
        chk("R9 ehci bursts", ehci_ctrl & 32'h3C00_0000, 32'h3C00_0000);
        chk("R9 ohci bit", ohci_ctrl, 32'h8);
        chk("R2 host fsel", {29'd0, host_ctrl[18:16]}, 2);
        chk("R10 host iso released", {31'd0, iso_host}, 0);
        compare_all("R6");
        @(negedge clk);
        chk("R12 done single", {31'd0, done}, 0);

        // device power-on: R4 R5 R2
        run_cmd(1'b1, 2'd0, 24000, cyc, e_seen, b_seen);
        model_apply(1'b1, 2'd0, 24000);
        chk("R5 device hold", otg_last, LONG_N);
        chk("R2 otg fsel", {29'd0, otg_ctrl[6:4]}, 5);
        chk("R4 mode device", {31'd0, mode_host}, 0);
        compare_all("R4");

        // inter-chip power-on leaves isolation alone: R10
        run_cmd(1'b1, 2'd2, 50000, cyc, e_seen, b_seen);
        model_apply(1'b1, 2'd2, 50000);
        compare_all("R10");

        // command during busy is ignored: R12
        @(negedge clk);
        cmd_valid = 1'b1; cmd_on = 1'b1; cmd_port = 2'd0; cmd_rate_khz = 16'd9600;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk("R12 busy mid", {31'd0, busy}, 1);
        cmd_valid = 1'b1; cmd_on = 1'b0; cmd_port = 2'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
        model_apply(1'b1, 2'd0, 9600);
        compare_all("R12 ignored");
        repeat (4) @(negedge clk);
        chk("R12 no second run", {31'd0, busy}, 0);

        // power-offs: R11
        run_cmd(1'b0, 2'd1, 0, cyc, e_seen, b_seen);
        model_apply(1'b0, 2'd1, 0);
        compare_all("R11 host");
        run_cmd(1'b0, 2'd0, 0, cyc, e_seen, b_seen);
        model_apply(1'b0, 2'd0, 0);
        compare_all("R11 dev");
        run_cmd(1'b0, 2'd3, 0, cyc, e_seen, b_seen);
        model_apply(1'b0, 2'd3, 0);
        compare_all("R11 hsic");

        // random mix
        for (int i = 0; i < 40; i++) begin
            logic on;
            logic [1:0] port;
            int khz;
            on = ($urandom_range(0, 2) != 0);
            port = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 4) == 0) begin
                khz = $urandom_range(1, 60000);
                if (rate_code(khz) >= 0) khz = khz + 1;
            end else begin
                khz = pick_rate($urandom_range(0, 6));
            end
            run_cmd(on, port, khz, cyc, e_seen, b_seen);
            model_apply(on, port, khz);
            if (on && rate_code(khz) < 0) begin
                chk("R3 random err", {31'd0, e_seen}, 1);
            end else begin
                chk("R12 random no err", {31'd0, e_seen}, 0);
                if (on) chk("R2 random fsel", {29'd0, otg_ctrl[6:4]}, rate_code(khz));
            end
            compare_all("R12 random");
        end

        chk("R10 iso release order", ord10, 0);
        chk("R11 iso before power-down", ord11, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule